// File: doc/BRIEF.md
# Motion Burst Reader and Delta Accumulator

This block services an optical motion sensor over a four-wire SPI link. When the sensor pulls its active-low motion interrupt low, the block opens one chip-select window and sends the burst command byte. It then clocks in a fixed seven-byte burst frame. From that frame it takes the X and Y displacements, each a signed 16-bit value split into a low byte and a high byte. It adds them into two 32-bit signed accumulators, which keep summing across any number of interrupts.

A host samples the motion by pulsing `report_req` for one cycle. On the next cycle the block presents `report_valid` with two 8-bit two's-complement values. Each value is the accumulated sum limited to the range -127..+127, and the X value has its sign inverted. Both accumulators return to zero at the same time. Sensor bring-up and the formatting of host reports are handled elsewhere.

The sequencer has six states:
- `ST_IDLE` goes to `ST_ADDR_GO` when an interrupt is pending.
- `ST_ADDR_GO` launches the command byte and moves to `ST_ADDR_WAIT`.
- `ST_ADDR_WAIT` moves to `ST_RD_GO` when the byte completes.
- `ST_RD_GO` launches a read byte and moves to `ST_RD_WAIT`.
- `ST_RD_WAIT` returns to `ST_RD_GO` after each byte. After the last byte it goes to `ST_COMMIT` instead.
- `ST_COMMIT` releases chip select, hands the displacements to the accumulators and goes back to `ST_IDLE`.

Top module: `motion_burst_accum`

## Requirements
- R1: While reset is held and right after it, `cs_n` and `sclk` are high, `report_valid` is low, and `rep_x` and `rep_y` are zero.
- R2: A high-to-low transition of `irq_n` starts one burst. It is detected after a two-flop synchronizer. Holding `irq_n` low, or a low-to-high transition, starts nothing.
- R3: Each burst is one `cs_n` low window. In that window the first byte sent on `mosi` is 0x50, which is the command 0x50 with bit 7 cleared. The byte is sent MSB first. After it exactly seven bytes are read, so the window holds 64 rising `sclk` edges, and then `cs_n` returns high.
- R4: The SPI link uses mode 3. `sclk` idles high. `mosi` changes only when `sclk` is low and is set at each falling edge. `miso` is sampled at each rising edge, MSB first. Each `sclk` half period lasts `HALF_DIV` clock cycles.
- R5: In the frame, byte 2 is the X low byte and byte 3 the X high byte. Byte 4 is the Y low byte and byte 5 the Y high byte. Bytes 0, 1 and 6 have no effect on the results.
- R6: Each 16-bit displacement is sign-extended and added to its own 32-bit signed accumulator. Sums beyond the 16-bit range are kept exactly.
- R7: `report_valid` is high in exactly the cycle after a `report_req` cycle. In that cycle `rep_y` is the Y sum limited to -127..+127, and `rep_x` is the negation of the X sum limited the same way. Both are 8-bit two's complement, and the value 0x80 never appears. `rep_x` and `rep_y` hold their values between reports.
- R8: A report returns both accumulators to zero, so a report with no burst in between yields zero on both axes.
- R9: A report and a burst completion can fall in the same cycle. In that case the report shows the sums from before that burst, and the burst's displacements become the new accumulator contents.
- R10: An `irq_n` falling edge that arrives while a burst is in progress is remembered. Exactly one further burst follows the current one, however many edges arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | Sensor motion interrupt, active low, asynchronous |
| sclk | output | 1 | SPI serial clock, idles high |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to the sensor |
| miso | input | 1 | SPI data from the sensor |
| report_req | input | 1 | One-cycle request to read out and clear the sums |
| report_valid | output | 1 | High for one cycle with the report values |
| rep_x | output | 8 | Limited and negated X sum, two's complement |
| rep_y | output | 8 | Limited Y sum, two's complement |

## Verification
The two functions that can meet in one cycle are the commit of a finished burst into the accumulators and the readout-and-clear of a report. The bench waits for `cs_n` to rise, which happens as the sequencer enters its commit state. It then raises `report_req` for exactly that commit cycle. The collision is judged at the ports. The report seen then must carry only the sums from before the burst, and a second report must return exactly the new burst's displacements. A second overlap is checked as well: interrupt edges arriving during an active burst must yield exactly one extra chip-select window and a doubled sum.

// File: rtl/motion_burst_pkg.sv
`timescale 1ns/1ps
package motion_burst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_GO,
        ST_ADDR_WAIT,
        ST_RD_GO,
        ST_RD_WAIT,
        ST_COMMIT
    } burst_state_t;

    localparam int BYTE_W  = 8;
    localparam int DELTA_W = 2 * BYTE_W;

    // positions of the displacement bytes inside the burst frame
    localparam int POS_X_LO = 2;
    localparam int POS_X_HI = 3;
    localparam int POS_Y_LO = 4;
    localparam int POS_Y_HI = 5;

endpackage

// File: rtl/irq_fall_sync.sv
`timescale 1ns/1ps
module irq_fall_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    // stages 0..STAGES-1 synchronize, stage STAGES holds the previous value
    logic [STAGES:0] chain_q;

    for (genvar s = 0; s <= STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[s] <= 1'b1;
            end else if (s == 0) begin
                chain_q[s] <= din;
            end else begin
                chain_q[s] <= chain_q[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign fall = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/spi_byte_engine.sv
`timescale 1ns/1ps
module spi_byte_engine
    import motion_burst_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BIT_W = $clog2(BYTE_W + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
    localparam logic [BIT_W-1:0] BIT_FULL = BIT_W'(BYTE_W);

    logic              busy_q;
    logic [DIV_W-1:0]  div_q;
    logic [BIT_W-1:0]  bits_q;
    logic [BYTE_W-1:0] tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            div_q   <= '0;
            bits_q  <= '0;
            tx_q    <= '0;
            rx_byte <= '0;
            sclk    <= 1'b1;
            mosi    <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy_q) begin
                // first falling edge launches the MSB
                busy_q <= 1'b1;
                sclk   <= 1'b0;
                mosi   <= tx_byte[BYTE_W-1];
                tx_q   <= {tx_byte[BYTE_W-2:0], 1'b0};
                bits_q <= '0;
                div_q  <= '0;
            end else if (busy_q) begin
                if (div_q == DIV_LAST) begin
                    div_q <= '0;
                    if (!sclk) begin
                        sclk    <= 1'b1;
                        rx_byte <= {rx_byte[BYTE_W-2:0], miso};
                        bits_q  <= bits_q + 1'b1;
                    end else if (bits_q == BIT_FULL) begin
                        busy_q <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        sclk <= 1'b0;
                        mosi <= tx_q[BYTE_W-1];
                        tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                    end
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/axis_accum.sv
`timescale 1ns/1ps
module axis_accum #(
    parameter int ACC_W   = 32,
    parameter int DELTA_W = 16,
    parameter int OUT_W   = 8,
    parameter bit NEGATE  = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     add_en,
    input  logic signed [DELTA_W-1:0] delta,
    input  logic                     clear,
    output logic signed [ACC_W-1:0]  acc,
    output logic [OUT_W-1:0]         rep
);
    localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] NEG_LIM = -POS_LIM;

    logic signed [ACC_W-1:0] delta_ext;
    logic signed [ACC_W-1:0] sat_val;
    logic signed [ACC_W-1:0] out_val;

    assign delta_ext = {{(ACC_W - DELTA_W){delta[DELTA_W-1]}}, delta};

    always_comb begin
        if (acc > POS_LIM)      sat_val = POS_LIM;
        else if (acc < NEG_LIM) sat_val = NEG_LIM;
        else                    sat_val = acc;
        out_val = NEGATE ? -sat_val : sat_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            rep <= '0;
        end else begin
            if (clear) begin
                rep <= out_val[OUT_W-1:0];
                acc <= add_en ? delta_ext : '0;
            end else if (add_en) begin
                acc <= acc + delta_ext;
            end
        end
    end
endmodule

// File: rtl/motion_burst_accum.sv
`timescale 1ns/1ps
module motion_burst_accum
    import motion_burst_pkg::*;
#(
    parameter int          HALF_DIV    = 2,
    parameter int          BURST_LEN   = 7,
    parameter int          ACC_W       = 32,
    parameter int          OUT_W       = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  BURST_CMD   = 8'h50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_n,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso,
    input  logic             report_req,
    output logic             report_valid,
    output logic [OUT_W-1:0] rep_x,
    output logic [OUT_W-1:0] rep_y
);
    localparam int IDX_W = $clog2(BURST_LEN);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BURST_LEN - 1);
    localparam logic [BYTE_W-1:0] CMD_RD = BURST_CMD & 8'h7F;

    burst_state_t state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic              pend_q;
    logic              irq_fall;
    logic              eng_start, eng_done;
    logic [BYTE_W-1:0] eng_tx, eng_rx;
    logic [BYTE_W-1:0] x_lo_q, x_hi_q, y_lo_q, y_hi_q;
    logic              commit_w;
    logic signed [DELTA_W-1:0] dx_w, dy_w;
    logic signed [ACC_W-1:0]   acc_x_w, acc_y_w;

    irq_fall_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(irq_n), .fall(irq_fall)
    );

    spi_byte_engine #(.HALF_DIV(HALF_DIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .tx_byte(eng_tx),
        .miso(miso), .sclk(sclk), .mosi(mosi), .done(eng_done), .rx_byte(eng_rx)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (pend_q)   state_d = ST_ADDR_GO;
            ST_ADDR_GO:                 state_d = ST_ADDR_WAIT;
            ST_ADDR_WAIT: if (eng_done) state_d = ST_RD_GO;
            ST_RD_GO:                   state_d = ST_RD_WAIT;
            ST_RD_WAIT:   if (eng_done) state_d = (idx_q == IDX_LAST) ? ST_COMMIT : ST_RD_GO;
            ST_COMMIT:                  state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        cs_n      = 1'b0;
        eng_start = 1'b0;
        eng_tx    = '0;
        commit_w  = 1'b0;
        unique case (state_q)
            ST_IDLE:      cs_n = 1'b1;
            ST_ADDR_GO:   begin eng_start = 1'b1; eng_tx = CMD_RD; end
            ST_ADDR_WAIT: ;
            ST_RD_GO:     eng_start = 1'b1;
            ST_RD_WAIT:   ;
            ST_COMMIT:    begin cs_n = 1'b1; commit_w = 1'b1; end
            default:      cs_n = 1'b1;
        endcase
    end

    // pending interrupt, byte index and frame capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            idx_q  <= '0;
            x_lo_q <= '0;
            x_hi_q <= '0;
            y_lo_q <= '0;
            y_hi_q <= '0;
        end else begin
            pend_q <= irq_fall | (pend_q & (state_q != ST_IDLE));
            if (state_q == ST_ADDR_GO) idx_q <= '0;
            if (state_q == ST_RD_WAIT && eng_done) begin
                idx_q <= idx_q + 1'b1;
                if (idx_q == IDX_W'(POS_X_LO)) x_lo_q <= eng_rx;
                if (idx_q == IDX_W'(POS_X_HI)) x_hi_q <= eng_rx;
                if (idx_q == IDX_W'(POS_Y_LO)) y_lo_q <= eng_rx;
                if (idx_q == IDX_W'(POS_Y_HI)) y_hi_q <= eng_rx;
            end
        end
    end

    assign dx_w = {x_hi_q, x_lo_q};
    assign dy_w = {y_hi_q, y_lo_q};

    axis_accum #(.ACC_W(ACC_W), .DELTA_W(DELTA_W), .OUT_W(OUT_W), .NEGATE(1'b1)) u_acc_x (
        .clk(clk), .rst_n(rst_n), .add_en(commit_w), .delta(dx_w),
        .clear(report_req), .acc(acc_x_w), .rep(rep_x)
    );

    axis_accum #(.ACC_W(ACC_W), .DELTA_W(DELTA_W), .OUT_W(OUT_W), .NEGATE(1'b0)) u_acc_y (
        .clk(clk), .rst_n(rst_n), .add_en(commit_w), .delta(dy_w),
        .clear(report_req), .acc(acc_y_w), .rep(rep_y)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) report_valid <= 1'b0;
        else        report_valid <= report_req;
    end
endmodule

// File: rtl/motion_burst_chk.sv
`timescale 1ns/1ps
module motion_burst_chk #(
    parameter int BURST_LEN = 7,
    parameter int ACC_W     = 32,
    parameter int DELTA_W   = 16,
    parameter int OUT_W     = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cs_n,
    input logic                      sclk,
    input logic                      mosi,
    input logic                      report_req,
    input logic                      report_valid,
    input logic [OUT_W-1:0]          rep_x,
    input logic [OUT_W-1:0]          rep_y,
    input logic                      commit,
    input logic signed [DELTA_W-1:0] dx,
    input logic signed [DELTA_W-1:0] dy,
    input logic signed [ACC_W-1:0]   acc_x,
    input logic signed [ACC_W-1:0]   acc_y
);
    localparam int EDGES = 8 * (BURST_LEN + 1);
    localparam logic [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

    logic cs_q, sclk_q;
    int unsigned rise_cnt;
    logic signed [ACC_W-1:0] dx_e, dy_e;

    assign dx_e = {{(ACC_W - DELTA_W){dx[DELTA_W-1]}}, dx};
    assign dy_e = {{(ACC_W - DELTA_W){dy[DELTA_W-1]}}, dy};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q     <= 1'b1;
            sclk_q   <= 1'b1;
            rise_cnt <= 0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
            if (cs_n)                rise_cnt <= 0;
            else if (sclk && !sclk_q) rise_cnt <= rise_cnt + 1;
        end
    end

    // R3
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !cs_q) |-> (rise_cnt == EDGES));

    // R4
    idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    // R4
    mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> !sclk);

    // R7
    rep_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        report_req |=> report_valid);

    // R7
    no_rep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !report_req |=> !report_valid);

    // R7
    rep_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        report_valid |-> (rep_x != MOST_NEG && rep_y != MOST_NEG));

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (report_req && !commit) |=> (acc_x == 0 && acc_y == 0));

    // R9
    collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (report_req && commit) |=> (acc_x == $past(dx_e) && acc_y == $past(dy_e)));
endmodule

bind motion_burst_accum motion_burst_chk #(
    .BURST_LEN(BURST_LEN), .ACC_W(ACC_W), .DELTA_W(16), .OUT_W(OUT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .report_req(report_req), .report_valid(report_valid),
    .rep_x(rep_x), .rep_y(rep_y), .commit(commit_w),
    .dx(dx_w), .dy(dy_w), .acc_x(acc_x_w), .acc_y(acc_y_w)
);

// File: tb/motion_burst_accum_tb_top.sv
`timescale 1ns/1ps
module motion_burst_accum_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_n = 1'b1;
    logic miso = 1'b0;
    logic report_req = 1'b0;
    logic sclk, cs_n, mosi, report_valid;
    logic [7:0] rep_x, rep_y;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // sensor model state
    logic [7:0] frame [0:6];
    int bitcnt = 0;
    logic [7:0] rx_addr = 8'h00;
    logic [7:0] last_addr = 8'h00;
    int last_bits = 0;
    int windows = 0;

    always #2.5 clk = ~clk;

    motion_burst_accum dut_i (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .sclk(sclk), .cs_n(cs_n),
        .mosi(mosi), .miso(miso), .report_req(report_req),
        .report_valid(report_valid), .rep_x(rep_x), .rep_y(rep_y)
    );

    always @(negedge cs_n) begin
        bitcnt  = 0;
        rx_addr = 8'h00;
    end

    always @(posedge sclk) begin
        if (!cs_n) begin
            if (bitcnt < 8) rx_addr = {rx_addr[6:0], mosi};
            bitcnt = bitcnt + 1;
        end
    end

    always @(negedge sclk) begin
        if (!cs_n && bitcnt >= 8 && bitcnt < 64)
            miso = frame[(bitcnt - 8) / 8][7 - ((bitcnt - 8) % 8)];
    end

    always @(posedge cs_n) begin
        if (rst_n) begin
            windows   = windows + 1;
            last_bits = bitcnt;
            last_addr = rx_addr;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampv(input int v);
        if (v > 127) return 127;
        if (v < -127) return -127;
        return v;
    endfunction

    task automatic set_frame(input int dx, input int dy, input int salt);
        frame[0] = 8'(8'hA5 ^ salt);
        frame[1] = 8'(8'h3C + salt);
        frame[2] = 8'(dx);
        frame[3] = 8'(dx >>> 8);
        frame[4] = 8'(dy);
        frame[5] = 8'(dy >>> 8);
        frame[6] = 8'(8'hE7 - salt);
    endtask

    task automatic pulse_irq(input int hold);
        @(negedge clk) irq_n = 1'b0;
        repeat (hold) @(negedge clk);
        irq_n = 1'b1;
    endtask

    task automatic wait_windows(input int target);
        for (int n = 0; n < 5000 && windows < target; n++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic do_report(input int sx, input int sy, input string req);
        @(negedge clk) report_req = 1'b1;
        @(negedge clk) report_req = 1'b0;
        chk(report_valid === 1'b1, {req, " valid"}, int'(report_valid), 1);
        chk(rep_x === 8'(-clampv(sx)), {req, " x"}, int'(rep_x), int'(8'(-clampv(sx))));
        chk(rep_y === 8'(clampv(sy)), {req, " y"}, int'(rep_y), int'(8'(clampv(sy))));
        @(negedge clk);
        chk(report_valid === 1'b0, {req, " valid drop"}, int'(report_valid), 0);
    endtask

    initial begin
        int vals [14] = '{0, 1, -1, 5, -3, 126, 127, 128, -127, -128, -129, 32767, -32768, 200};
        int w;
        set_frame(0, 0, 0);
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(cs_n === 1'b1, "R1 cs_n", int'(cs_n), 1);
        chk(sclk === 1'b1, "R1 sclk", int'(sclk), 1);
        chk(report_valid === 1'b0, "R1 valid", int'(report_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n === 1'b1 && sclk === 1'b1, "R1 after reset idle", int'({cs_n, sclk}), 3);
        chk(rep_x === 8'd0 && rep_y === 8'd0, "R1 outputs zero", int'({rep_x, rep_y}), 0);

        // sweep of single-burst displacements: R3 R5 R7 R8
        for (int i = 0; i < 14; i++) begin
            int dx = vals[i];
            int dy = vals[(i + 5) % 14];
            set_frame(dx, dy, i * 17);
            w = windows;
            pulse_irq(3);
            wait_windows(w + 1);
            chk(last_addr === 8'h50, "R3 command byte", int'(last_addr), 8'h50);
            chk(last_bits == 64, "R3 edge count", last_bits, 64);
            do_report(dx, dy, "R5 R7 sweep");
            do_report(0, 0, "R8 cleared");
        end

        // R6 sums beyond 16 bits kept
        set_frame(30000, -20000, 3);
        w = windows;
        pulse_irq(3); wait_windows(w + 1);
        pulse_irq(3); wait_windows(w + 2);
        do_report(60000, -40000, "R6 wide sum");
        set_frame(100, -60, 9);
        w = windows;
        pulse_irq(3); wait_windows(w + 1);
        set_frame(-50, 30, 1);
        pulse_irq(3); wait_windows(w + 2);
        do_report(50, -30, "R6 mixed sum");

        // R2 long low level and rising edge start nothing extra
        set_frame(11, 12, 5);
        w = windows;
        pulse_irq(60);
        repeat (600) @(negedge clk);
        chk(windows == w + 1, "R2 one burst per fall", windows - w, 1);
        do_report(11, 12, "R2 value");

        // R10 edges during a burst give one more burst
        set_frame(7, -2, 2);
        w = windows;
        pulse_irq(3);
        for (int n = 0; n < 100 && cs_n; n++) @(negedge clk);
        pulse_irq(3);
        pulse_irq(3);
        wait_windows(w + 2);
        repeat (600) @(negedge clk);
        chk(windows == w + 2, "R10 pending burst count", windows - w, 2);
        do_report(14, -4, "R10 sum");

        // R9 report in the commit cycle
        set_frame(9, 4, 6);
        w = windows;
        pulse_irq(3); wait_windows(w + 1);
        set_frame(20, -6, 7);
        pulse_irq(3);
        @(posedge cs_n);
        @(negedge clk) report_req = 1'b1;
        @(negedge clk) report_req = 1'b0;
        chk(report_valid === 1'b1, "R9 valid", int'(report_valid), 1);
        chk(rep_x === 8'(-9), "R9 prior x", int'(rep_x), int'(8'(-9)));
        chk(rep_y === 8'(4), "R9 prior y", int'(rep_y), 4);
        repeat (3) @(negedge clk);
        do_report(20, -6, "R9 kept delta");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule